// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of small single-layer perceptrons. The low bits of the branch address pick one table row. That row holds one signed bias weight and one signed weight for each bit of a global outcome history. The prediction comes from the sign of the weighted sum. Each history bit counts as +1 when the branch was taken and -1 when it was not.

A fetch stage sends a PC on the predict port. One cycle later it receives the direction and the raw sum. When the branch retires, the back end returns the PC, the real outcome and the sum it was given. The block then decides whether to train the selected row, and it always shifts the real outcome into the history. Training happens on a wrong guess, and also on a correct guess whose sum lies close to zero.

Top module: `perc_predictor`

## Requirements
- R1: After a synchronous active-low reset, every weight and every history bit is zero. The first prediction for any PC therefore has sum 0 and is taken.
- R2: The row is chosen by PC bits [log2(ENTRIES)-1:0] only. Two PCs that differ only above those bits read and train the same row.
- R3: The sum equals the bias weight plus, for each i in 1..HIST_LEN, the weight w_i added when history bit i-1 is 1 (taken) and subtracted when it is 0. History bit 0 holds the most recently resolved outcome.
- R4: The prediction is taken exactly when the two's-complement sum is greater than or equal to zero.
- R5: `pred_valid_o`, `pred_taken_o` and `pred_sum_o` belong to the PC presented with `pred_valid_i` one clock earlier. `pred_valid_o` is low in a cycle that follows no request.
- R6: A resolve trains the row when (`res_sum_i` >= 0) differs from `res_taken_i`, or when |`res_sum_i`| < THETA = floor(1.93*HIST_LEN + 14), which is 79 by default. Otherwise no weight changes.
- R7: Training moves the bias by +1 for a taken outcome and by -1 for a not-taken outcome. It moves each w_i by +1 when history bit i-1 equals the outcome and by -1 when it does not, using the history as it was before that resolve.
- R8: Weights are 8-bit signed and saturate: they never go above +127 or below -128.
- R9: Every resolve shifts `res_taken_i` into history bit 0 and moves the older bits up by one position, whether or not training happens.
- R10: A predict and a resolve in the same cycle on the same row return the weights as they were before that resolve's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_valid_i | input | 1 | Prediction request |
| pred_pc_i | input | PC_W | Branch address to predict |
| pred_valid_o | output | 1 | Prediction outputs valid this cycle |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_sum_o | output | SUM_W | Perceptron output sum, two's complement |
| res_valid_i | input | 1 | Resolved branch present |
| res_pc_i | input | PC_W | Address of the resolved branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| res_sum_i | input | SUM_W | Sum returned with the earlier prediction |

## Verification
The checker watches the predict-port timing on every cycle. It also checks the history shift, and that its contents hold still when no resolve arrives. It checks the sign rule that links the sum to the direction, and that a confident, correct resolve never raises the table write. The arithmetic of the sum, the update rule, saturation at both ends, row aliasing and the same-cycle read ordering show up only in the bench scenarios. There a behavioural model of the weights and history predicts every sum.

// File: rtl/perc_pkg.sv
// Shared weight type, saturating step and training threshold for the
// perceptron predictor. Assumes 8-bit two's-complement weights.
package perc_pkg;
    localparam int WEIGHT_W = 8;
    typedef logic signed [WEIGHT_W-1:0] weight_t;
    localparam weight_t W_MAX = 8'sd127;
    localparam weight_t W_MIN = -8'sd128;

    // Move a weight one step up or down, clamped at the type limits.
    function automatic weight_t step_weight(weight_t w, logic up);
        if (up) return (w == W_MAX) ? w : weight_t'(w + 8'sd1);
        return (w == W_MIN) ? w : weight_t'(w - 8'sd1);
    endfunction

    // Training threshold floor(1.93*n + 14) in integer arithmetic.
    function automatic int theta_of(int n);
        return (193 * n + 1400) / 100;
    endfunction
endpackage

// File: rtl/perc_ghr.sv
// Global outcome history shift register. Bit 0 is the newest outcome.
// Assumes HIST_LEN >= 2 and shifts only on resolved branches.
module perc_ghr #(
    parameter int HIST_LEN = 34
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic                taken_i,
    output logic [HIST_LEN-1:0] hist_o
);
    // Clear on reset; insert the resolved outcome on each resolve.
    always_ff @(posedge clk) begin
        if (!rst_n)       hist_o <= '0;
        else if (shift_i) hist_o <= {hist_o[HIST_LEN-2:0], taken_i};
    end
endmodule

// File: rtl/perc_table.sv
// Perceptron weight table. It has one registered read for prediction,
// one combinational read for training and one write port. A registered
// read in the same cycle as a write to that row returns the old row.
module perc_table
    import perc_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter int HIST_LEN = 34,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output weight_t [HIST_LEN:0]      rd_row_o,
    input  logic [IDX_W-1:0]          rsv_idx_i,
    output weight_t [HIST_LEN:0]      rsv_row_o,
    input  logic                      wr_en_i,
    input  weight_t [HIST_LEN:0]      wr_row_i
);
    weight_t [HIST_LEN:0] mem [ENTRIES];

    // Zero every row on reset; otherwise apply a training write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (wr_en_i) begin
            mem[rsv_idx_i] <= wr_row_i;
        end
    end

    // Capture the requested row for the prediction path.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_row_o <= '0;
        else if (rd_en_i) rd_row_o <= mem[rd_idx_i];
    end

    // Row under training, read without delay.
    assign rsv_row_o = mem[rsv_idx_i];
endmodule

// File: rtl/perc_dot.sv
// Combinational perceptron output: the bias plus the sum of weights
// signed by the history bits (1 adds the weight, 0 subtracts it).
module perc_dot
    import perc_pkg::*;
#(
    parameter int HIST_LEN = 34,
    parameter int SUM_W    = 14
) (
    input  weight_t [HIST_LEN:0]      row_i,
    input  logic [HIST_LEN-1:0]       hist_i,
    output logic signed [SUM_W-1:0]   sum_o
);
    // Accumulate the signed dot product over the history bits.
    always_comb begin
        logic signed [SUM_W-1:0] acc;
        logic signed [SUM_W-1:0] ext;
        acc = SUM_W'($signed(row_i[0]));
        for (int i = 1; i <= HIST_LEN; i++) begin
            ext = SUM_W'($signed(row_i[i]));
            if (hist_i[i-1]) acc = acc + ext;
            else             acc = acc - ext;
        end
        sum_o = acc;
    end
endmodule

// File: rtl/perc_train.sv
// Training decision and weight update for a resolved branch. The row
// trains when the sign of the sum was wrong or its magnitude is below
// theta; each weight moves one saturating step toward agreement.
module perc_train
    import perc_pkg::*;
#(
    parameter int HIST_LEN = 34,
    parameter int SUM_W    = 14
) (
    input  logic                      valid_i,
    input  logic                      taken_i,
    input  logic signed [SUM_W-1:0]   sum_i,
    input  logic [HIST_LEN-1:0]       hist_i,
    input  weight_t [HIST_LEN:0]      row_i,
    output logic                      wr_en_o,
    output weight_t [HIST_LEN:0]      row_o
);
    localparam logic [SUM_W-1:0] THETA = SUM_W'(theta_of(HIST_LEN));

    logic             guess_taken;
    logic [SUM_W-1:0] magnitude;

    // Decide whether this resolve updates the row.
    always_comb begin
        guess_taken = !sum_i[SUM_W-1];
        magnitude   = sum_i[SUM_W-1] ? SUM_W'(-sum_i) : SUM_W'(sum_i);
        wr_en_o     = valid_i && ((guess_taken != taken_i) || (magnitude < THETA));
    end

    assign row_o[0] = step_weight(row_i[0], taken_i);
    for (genvar i = 1; i <= HIST_LEN; i++) begin : g_step
        assign row_o[i] = step_weight(row_i[i], hist_i[i-1] == taken_i);
    end
endmodule

// File: rtl/perc_predictor.sv
// Perceptron branch direction predictor top. A PC on the predict port
// yields a direction and sum one cycle later. A resolve trains the
// addressed row and shifts the real outcome into the global history.
// Assumes ENTRIES is a power of two and resolves arrive in order.
module perc_predictor
    import perc_pkg::*;
#(
    parameter int  ENTRIES  = 32,
    parameter int  HIST_LEN = 34,
    parameter int  PC_W     = 32,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int SUM_W    = $clog2((HIST_LEN + 1) * 128 + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pred_valid_i,
    input  logic [PC_W-1:0]  pred_pc_i,
    output logic             pred_valid_o,
    output logic             pred_taken_o,
    output logic [SUM_W-1:0] pred_sum_o,
    input  logic             res_valid_i,
    input  logic [PC_W-1:0]  res_pc_i,
    input  logic             res_taken_i,
    input  logic [SUM_W-1:0] res_sum_i
);
    logic [HIST_LEN-1:0]     ghr_q;
    logic [HIST_LEN-1:0]     hist_snap_q;
    weight_t [HIST_LEN:0]    pred_row;
    weight_t [HIST_LEN:0]    rsv_row;
    weight_t [HIST_LEN:0]    new_row;
    logic                    train_wr;
    logic signed [SUM_W-1:0] sum_w;
    logic                    unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc_i[PC_W-1:IDX_W], res_pc_i[PC_W-1:IDX_W]};

    perc_ghr #(.HIST_LEN(HIST_LEN)) u_ghr (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (res_valid_i),
        .taken_i (res_taken_i),
        .hist_o  (ghr_q)
    );

    perc_table #(.ENTRIES(ENTRIES), .HIST_LEN(HIST_LEN)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (pred_valid_i),
        .rd_idx_i  (pred_pc_i[IDX_W-1:0]),
        .rd_row_o  (pred_row),
        .rsv_idx_i (res_pc_i[IDX_W-1:0]),
        .rsv_row_o (rsv_row),
        .wr_en_i   (train_wr),
        .wr_row_i  (new_row)
    );

    perc_train #(.HIST_LEN(HIST_LEN), .SUM_W(SUM_W)) u_train (
        .valid_i (res_valid_i),
        .taken_i (res_taken_i),
        .sum_i   ($signed(res_sum_i)),
        .hist_i  (ghr_q),
        .row_i   (rsv_row),
        .wr_en_o (train_wr),
        .row_o   (new_row)
    );

    // Hold the history seen by the request beside its table read.
    always_ff @(posedge clk) begin
        if (!rst_n)            hist_snap_q <= '0;
        else if (pred_valid_i) hist_snap_q <= ghr_q;
    end

    // Mark the cycle in which the prediction outputs are meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) pred_valid_o <= 1'b0;
        else        pred_valid_o <= pred_valid_i;
    end

    perc_dot #(.HIST_LEN(HIST_LEN), .SUM_W(SUM_W)) u_dot (
        .row_i  (pred_row),
        .hist_i (hist_snap_q),
        .sum_o  (sum_w)
    );

    assign pred_sum_o   = sum_w;
    assign pred_taken_o = !sum_w[SUM_W-1];
endmodule

// File: rtl/perc_predictor_chk.sv
// Protocol and history checks for perc_predictor, bound to every instance.
module perc_predictor_chk
    import perc_pkg::*;
#(
    parameter int HIST_LEN = 34,
    parameter int SUM_W    = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pred_valid_i,
    input logic                pred_valid_o,
    input logic                pred_taken_o,
    input logic [SUM_W-1:0]    pred_sum_o,
    input logic                res_valid_i,
    input logic                res_taken_i,
    input logic [SUM_W-1:0]    res_sum_i,
    input logic [HIST_LEN-1:0] hist,
    input logic                wr_en
);
    localparam int THETA = theta_of(HIST_LEN);

    int  res_mag;
    logic res_confident_right;
    always_comb begin
        res_mag = $signed(res_sum_i) < 0 ? -int'($signed(res_sum_i)) : int'($signed(res_sum_i));
        res_confident_right = (($signed(res_sum_i) >= 0) == res_taken_i) && (res_mag >= THETA);
    end

    // R5
    pred_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_i |=> pred_valid_o);
    // R5
    pred_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_i |=> !pred_valid_o);
    // R4
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> (pred_taken_o == ($signed(pred_sum_o) >= 0)));
    // R9
    hist_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_i |=> (hist[0] == $past(res_taken_i)) && (hist[HIST_LEN-1:1] == $past(hist[HIST_LEN-2:0])));
    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_i |=> $stable(hist));
    // R6
    no_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && res_confident_right) |-> !wr_en);
endmodule

bind perc_predictor perc_predictor_chk #(.HIST_LEN(HIST_LEN), .SUM_W(SUM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pred_valid_i (pred_valid_i),
    .pred_valid_o (pred_valid_o),
    .pred_taken_o (pred_taken_o),
    .pred_sum_o   (pred_sum_o),
    .res_valid_i  (res_valid_i),
    .res_taken_i  (res_taken_i),
    .res_sum_i    (res_sum_i),
    .hist         (ghr_q),
    .wr_en        (train_wr)
);

// File: tb/perc_predictor_test.sv
module perc_predictor_test;
    localparam int ENTRIES  = 32;
    localparam int HIST_LEN = 34;
    localparam int PC_W     = 32;
    localparam int SUM_W    = $clog2((HIST_LEN + 1) * 128 + 1) + 1;
    localparam int THETA    = (193 * HIST_LEN + 1400) / 100;
    localparam int NVEC     = 16;
    // Each vector: {pc[31:0], outcome}
    localparam logic [32:0] VEC [NVEC] = '{
        {32'h0000_0040, 1'b1}, {32'h0000_0044, 1'b0}, {32'h0000_0040, 1'b1},
        {32'h0000_1040, 1'b1}, {32'h0000_0048, 1'b0}, {32'h0000_0044, 1'b1},
        {32'h0000_0040, 1'b0}, {32'h0000_005C, 1'b1}, {32'h0000_0048, 1'b1},
        {32'h0000_0040, 1'b1}, {32'h0000_0044, 1'b0}, {32'h0000_005C, 1'b0},
        {32'h0000_1040, 1'b1}, {32'h0000_0048, 1'b0}, {32'h0000_0040, 1'b1},
        {32'h0000_0044, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pred_valid_i = 1'b0;
    logic [PC_W-1:0]  pred_pc_i = '0;
    logic             pred_valid_o;
    logic             pred_taken_o;
    logic [SUM_W-1:0] pred_sum_o;
    logic             res_valid_i = 1'b0;
    logic [PC_W-1:0]  res_pc_i = '0;
    logic             res_taken_i = 1'b0;
    logic [SUM_W-1:0] res_sum_i = '0;

    int checks = 0;
    int fails  = 0;
    int mw [ENTRIES][HIST_LEN+1];
    bit mh [HIST_LEN];
    bit done = 0;

    always #4 clk = ~clk;

    perc_predictor #(.ENTRIES(ENTRIES), .HIST_LEN(HIST_LEN), .PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
        .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o), .pred_sum_o(pred_sum_o),
        .res_valid_i(res_valid_i), .res_pc_i(res_pc_i),
        .res_taken_i(res_taken_i), .res_sum_i(res_sum_i)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_sum(logic [PC_W-1:0] pc);
        int idx = int'(pc) % ENTRIES;
        int s = mw[idx][0];
        for (int i = 1; i <= HIST_LEN; i++) s += mh[i-1] ? mw[idx][i] : -mw[idx][i];
        return s;
    endfunction

    function automatic int clampi(int v);
        return v > 127 ? 127 : (v < -128 ? -128 : v);
    endfunction

    task automatic m_resolve(logic [PC_W-1:0] pc, bit tk, int s);
        int idx = int'(pc) % ENTRIES;
        int mag = s < 0 ? -s : s;
        if (((s >= 0) != tk) || mag < THETA) begin
            mw[idx][0] = clampi(mw[idx][0] + (tk ? 1 : -1));
            for (int i = 1; i <= HIST_LEN; i++)
                mw[idx][i] = clampi(mw[idx][i] + ((mh[i-1] == tk) ? 1 : -1));
        end
        for (int i = HIST_LEN - 1; i > 0; i--) mh[i] = mh[i-1];
        mh[0] = tk;
    endtask

    // Issue a prediction and sample its result at the following falling edge.
    task automatic predict(logic [PC_W-1:0] pc, output int s, output bit tk);
        pred_valid_i = 1'b1; pred_pc_i = pc;
        @(negedge clk);
        pred_valid_i = 1'b0;
        chk("R5 valid", int'(pred_valid_o), 1);
        s = int'($signed(pred_sum_o));
        tk = pred_taken_o;
    endtask

    task automatic resolve(logic [PC_W-1:0] pc, bit tk, int s);
        res_valid_i = 1'b1; res_pc_i = pc; res_taken_i = tk; res_sum_i = SUM_W'(s);
        @(negedge clk);
        res_valid_i = 1'b0;
        m_resolve(pc, tk, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s, e;
        bit tk;
        for (int r = 0; r < ENTRIES; r++) for (int i = 0; i <= HIST_LEN; i++) mw[r][i] = 0;
        for (int i = 0; i < HIST_LEN; i++) mh[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 idle", int'(pred_valid_o), 0);

        // R1 R4: cleared state predicts sum 0, taken
        predict(32'h0000_0074, s, tk);
        chk("R1 reset sum", s, 0);
        chk("R4 zero taken", int'(tk), 1);

        // Table walk: R3 sum, R4 sign, R7 update, R9 history via model
        for (int v = 0; v < NVEC; v++) begin
            e = m_sum(VEC[v][32:1]);
            predict(VEC[v][32:1], s, tk);
            chk("R3 R7 R9 sum", s, e);
            chk("R4 direction", int'(tk), int'(e >= 0));
            resolve(VEC[v][32:1], VEC[v][0], s);
        end

        // R2: aliasing PCs share a row
        predict(32'h0000_0040, s, tk);
        begin
            int s2;
            bit t2;
            predict(32'hABCD_0040, s2, t2);
            chk("R2 alias", s2, s);
            chk("R2 row", s, m_sum(32'h0000_0040));
        end

        // R6: confident correct resolve leaves the row alone
        predict(32'h0000_0007, s, tk);
        chk("R6 fresh", s, 0);
        resolve(32'h0000_0007, 1'b1, THETA);
        predict(32'h0000_0007, s, tk);
        chk("R6 no train", s, m_sum(32'h0000_0007));
        chk("R6 unchanged bias-free", s, 0);
        resolve(32'h0000_0007, 1'b1, THETA - 1);
        predict(32'h0000_0007, s, tk);
        chk("R6 low conf train", s, m_sum(32'h0000_0007));
        resolve(32'h0000_0008, 1'b1, -500);
        predict(32'h0000_0008, s, tk);
        chk("R6 mispredict train", s, m_sum(32'h0000_0008));

        // R8: drive row 9 to positive saturation
        for (int k = 0; k < 300; k++) resolve(32'h0000_0009, 1'b1, -1);
        predict(32'h0000_0009, s, tk);
        chk("R8 max", s, (HIST_LEN + 1) * 127);
        // R8: bias to negative saturation, history weights stay at the top
        for (int k = 0; k < 300; k++) resolve(32'h0000_0009, 1'b0, 0);
        predict(32'h0000_0009, s, tk);
        chk("R8 min model", s, m_sum(32'h0000_0009));
        chk("R8 min", s, -128 - HIST_LEN * 127);

        // R10: same-cycle predict and resolve on one row sees old weights
        e = m_sum(32'h0000_000A);
        pred_valid_i = 1'b1; pred_pc_i = 32'h0000_000A;
        res_valid_i = 1'b1; res_pc_i = 32'h0000_002A; res_taken_i = 1'b1; res_sum_i = '0;
        @(negedge clk);
        pred_valid_i = 1'b0; res_valid_i = 1'b0;
        chk("R10 old row", int'($signed(pred_sum_o)), e);
        m_resolve(32'h0000_002A, 1'b1, 0);
        predict(32'h0000_000A, s, tk);
        chk("R10 after update", s, m_sum(32'h0000_000A));

        // R1: reset again clears weights and history
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        predict(32'h0000_0009, s, tk);
        chk("R1 re-reset", s, 0);

        finish_run();
    end
endmodule